// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

The block folds five reset requests into a single active-low core reset. The requests are a power-on request, a brown-out level, a watchdog expiry pulse, an active-low external pin and a keyed software write. The core stays in reset while any request is active and while the supply-good or oscillator-stable inputs are low. Once every condition is clean, a programmable count of clock cycles must pass before the core is let go, so the first fetch never lands on an unsettled clock. A power-on request asserts core reset asynchronously. Every other release and assertion happens on the clock edge.

A five-bit cause register records which sources have fired. The flags are sticky, so they survive the resets they cause. A power-on request wipes them and leaves only its own flag set. Firmware reads the flags over a small register port and clears them write-one-to-clear. The brown-out and pin inputs cross into the clock domain through a synchronizer chain.

The sequencer runs three states. `ST_HOLD` keeps the core in reset. `ST_WAIT` counts the start-up delay. `ST_RUN` releases the core. The transitions are:
- `ST_HOLD`→`ST_WAIT` when no request is active and the supply and oscillator are good.
- `ST_WAIT`→`ST_RUN` when the delay count reaches the configured value.
- `ST_WAIT`→`ST_HOLD` and `ST_RUN`→`ST_HOLD` on any request or on loss of supply or oscillator.
- Any state→`ST_HOLD` on the power-on request, which acts as an asynchronous reset.

Top module: `rstgen_top`

## Requirements
- R1: While `por_req` is high, `core_rst_n` is 0 without waiting for a clock edge. The cause register then reads 0x01, meaning only the power-on flag (bit 0) is set.
- R2: `core_rst_n` stays 0 while `supply_ok` or `osc_ok` is low. If either drops while the core runs, `core_rst_n` falls at the next edge and no cause flag changes.
- R3: Call the first clock edge at which no request is active and both `supply_ok` and `osc_ok` are high E0, and let D be `cfg_delay`. `core_rst_n` rises at edge E0+D+1, and this holds for every D from 0 to the largest value the field can hold.
- R4: A one-cycle `wdt_expire` pulse pulls `core_rst_n` low at that same edge and sets cause bit 2.
- R5: Let E1 be the first clock edge after `ext_rst_n` goes low. `core_rst_n` falls at edge E1+2 and cause bit 3 is set. Reset is held while the pin stays low. After the pin rises, the delay of R3 starts two edges later than the edge at which the pin was first seen high.
- R6: `bod_det` high is handled like the pin with inverted polarity, with the same two-edge synchronizer latency. It sets cause bit 1 and holds reset while the level stays high.
- R7: Writing 0xA5 to address 1 asserts core reset at that edge and sets cause bit 4. Any other value written to address 1 changes neither `core_rst_n` nor the flags.
- R8: A source other than power-on sets only its own flag and leaves the others unchanged. Flags persist through the core resets they cause.
- R9: A write to address 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0. A source active in the same cycle wins over the clear.
- R10: Any reset request during the start-up delay returns the sequencer to `ST_HOLD`, and the full delay restarts from the next clean edge.
- R11: `reg_rdata` shows the flags in bits 4:0 with zeros above when `reg_addr` is 0. It reads zero for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| bod_det | input | 1 | Brown-out detect level, asynchronous, active high |
| wdt_expire | input | 1 | Watchdog timeout pulse, synchronous |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| supply_ok | input | 1 | Supply-good level, synchronous |
| osc_ok | input | 1 | Oscillator-stable level, synchronous |
| cfg_delay | input | DLY_W | Start-up delay in clock cycles |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 cause flags, 1 software reset key |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
The bench builds the block with `DLY_W` narrowed to 4, so the largest delay of 15 can be reached alongside a zero delay and mid-range values. Exact release edges are then counted at both extremes. `SYNC_STAGES` is left at 2, which fixes the pin and brown-out latencies the bench expects at an exact edge. A delay of 10 leaves room to inject a second watchdog pulse partway through the count, which makes a missed restart visible as an early release.

// File: rtl/rstgen_pkg.sv
`timescale 1ns/1ps
package rstgen_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    // cause flag positions, as firmware sees them
    localparam int N_CAUSE = 5;
    localparam int C_POR   = 0;
    localparam int C_BOD   = 1;
    localparam int C_WDT   = 2;
    localparam int C_EXT   = 3;
    localparam int C_SW    = 4;

    typedef struct packed {
        logic sw;
        logic ext;
        logic wdt;
        logic bod;
    } req_t;

endpackage

// File: rtl/rstgen_sync.sv
`timescale 1ns/1ps
module rstgen_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rstgen_seq.sv
`timescale 1ns/1ps
module rstgen_seq
    import rstgen_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             req_any,
    input  logic             pwr_good,
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             core_rst_n
);

    seq_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic             blocked;

    assign blocked = req_any || !pwr_good;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!blocked) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (blocked)                  state_d = ST_HOLD;
                else if (cnt_q >= cfg_delay)  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (blocked) state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // delay counter: runs only while the wait state persists
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
        end else if (state_q == ST_WAIT && state_d == ST_WAIT) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            core_rst_n <= 1'b0;
        end else begin
            core_rst_n <= (state_d == ST_RUN);
        end
    end

endmodule

// File: rtl/rstgen_cause.sv
`timescale 1ns/1ps
module rstgen_cause
    import rstgen_pkg::*;
(
    input  logic               clk,
    input  logic               arst,
    input  logic [N_CAUSE-1:1] set_req,
    input  logic               clr_wr,
    input  logic [N_CAUSE-1:0] clr_mask,
    output logic [N_CAUSE-1:0] flags
);

    for (genvar i = 0; i < N_CAUSE; i++) begin : g_flag
        logic flag_q;
        if (i == C_POR) begin : g_por
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    flag_q <= 1'b1;
                end else if (clr_wr && clr_mask[i]) begin
                    flag_q <= 1'b0;
                end
            end
        end else begin : g_src
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    flag_q <= 1'b0;
                end else if (set_req[i]) begin
                    flag_q <= 1'b1;
                end else if (clr_wr && clr_mask[i]) begin
                    flag_q <= 1'b0;
                end
            end
        end
        assign flags[i] = flag_q;
    end

endmodule

// File: rtl/rstgen_regs.sv
`timescale 1ns/1ps
module rstgen_regs
    import rstgen_pkg::*;
#(
    parameter int                ADDR_W = 2,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] SW_KEY = 8'hA5
) (
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [N_CAUSE-1:0] flags,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               clr_wr,
    output logic [N_CAUSE-1:0] clr_mask,
    output logic               sw_hit
);

    localparam logic [ADDR_W-1:0] ADR_CAUSE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_SWRST = ADDR_W'(1);
    localparam int                PAD_W     = DATA_W - N_CAUSE;

    assign clr_wr    = reg_wr && (reg_addr == ADR_CAUSE);
    assign clr_mask  = reg_wdata[N_CAUSE-1:0];
    assign sw_hit    = reg_wr && (reg_addr == ADR_SWRST) && (reg_wdata == SW_KEY);
    assign reg_rdata = (reg_addr == ADR_CAUSE) ? {{PAD_W{1'b0}}, flags} : '0;

endmodule

// File: rtl/rstgen_top.sv
`timescale 1ns/1ps
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int                DLY_W       = 8,
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 2,
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] SW_KEY      = 8'hA5
) (
    input  logic              clk,
    input  logic              por_req,
    input  logic              bod_det,
    input  logic              wdt_expire,
    input  logic              ext_rst_n,
    input  logic              supply_ok,
    input  logic              osc_ok,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              core_rst_n
);

    // bit 0: brown-out level, bit 1: pin level (idles high)
    localparam logic [1:0] SYNC_RST = 2'b10;

    logic [1:0]         async_raw, async_s;
    req_t               req;
    logic               req_any;
    logic               sw_hit;
    logic               clr_wr;
    logic [N_CAUSE-1:0] clr_mask;
    logic [N_CAUSE-1:0] cause_flags;
    logic [N_CAUSE-1:1] cause_set;

    assign async_raw = {ext_rst_n, bod_det};

    rstgen_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk  (clk),
        .arst (por_req),
        .d    (async_raw),
        .q    (async_s)
    );

    assign req.bod = async_s[0];
    assign req.ext = ~async_s[1];
    assign req.wdt = wdt_expire;
    assign req.sw  = sw_hit;
    assign req_any = |req;

    assign cause_set[C_BOD] = req.bod;
    assign cause_set[C_WDT] = req.wdt;
    assign cause_set[C_EXT] = req.ext;
    assign cause_set[C_SW]  = req.sw;

    rstgen_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SW_KEY (SW_KEY)
    ) i_regs (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (cause_flags),
        .reg_rdata (reg_rdata),
        .clr_wr    (clr_wr),
        .clr_mask  (clr_mask),
        .sw_hit    (sw_hit)
    );

    rstgen_cause i_cause (
        .clk      (clk),
        .arst     (por_req),
        .set_req  (cause_set),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags    (cause_flags)
    );

    rstgen_seq #(
        .DLY_W (DLY_W)
    ) i_seq (
        .clk        (clk),
        .arst       (por_req),
        .req_any    (req_any),
        .pwr_good   (supply_ok && osc_ok),
        .cfg_delay  (cfg_delay),
        .core_rst_n (core_rst_n)
    );

endmodule

// File: rtl/rstgen_chk.sv
`timescale 1ns/1ps
module rstgen_chk
    import rstgen_pkg::*;
#(
    parameter int                ADDR_W = 2,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] SW_KEY = 8'hA5
) (
    input logic               clk,
    input logic               por_req,
    input logic               wdt_expire,
    input logic               supply_ok,
    input logic               osc_ok,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               core_rst_n,
    input logic [N_CAUSE-1:0] flags
);

    localparam logic [N_CAUSE-1:0] POR_ONLY = N_CAUSE'(1);

    logic wr_cause, wr_key;
    assign wr_cause = reg_wr && (reg_addr == ADDR_W'(0));
    assign wr_key   = reg_wr && (reg_addr == ADDR_W'(1)) && (reg_wdata == SW_KEY);

    assert_por_state_R1: assert property (@(posedge clk)
        por_req |-> (!core_rst_n && flags == POR_ONLY));

    assert_hold_on_power_R2: assert property (@(posedge clk) disable iff (por_req)
        (!supply_ok || !osc_ok) |=> !core_rst_n);

    assert_release_clean_R2: assert property (@(posedge clk) disable iff (por_req)
        $rose(core_rst_n) |-> $past(supply_ok && osc_ok && !wdt_expire));

    assert_wdt_reset_R4: assert property (@(posedge clk) disable iff (por_req)
        wdt_expire |=> (!core_rst_n && flags[C_WDT]));

    assert_sw_key_R7: assert property (@(posedge clk) disable iff (por_req)
        wr_key |=> (!core_rst_n && flags[C_SW]));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (por_req)
        !wr_cause |=> ((flags & $past(flags)) == $past(flags)));

    assert_w1c_R9: assert property (@(posedge clk) disable iff (por_req)
        (wr_cause && reg_wdata[C_WDT] && !wdt_expire) |=> !flags[C_WDT]);

endmodule

bind rstgen_top rstgen_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SW_KEY (SW_KEY)
) i_chk (
    .clk        (clk),
    .por_req    (por_req),
    .wdt_expire (wdt_expire),
    .supply_ok  (supply_ok),
    .osc_ok     (osc_ok),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .core_rst_n (core_rst_n),
    .flags      (cause_flags)
);

// File: tb/test_rstgen_top.sv
`timescale 1ns/1ps
module test_rstgen_top;

    localparam int DLY_W  = 4;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              por_req = 1'b0;
    logic              bod_det = 1'b0;
    logic              wdt_expire = 1'b0;
    logic              ext_rst_n = 1'b1;
    logic              supply_ok = 1'b0;
    logic              osc_ok = 1'b0;
    logic [DLY_W-1:0]  cfg_delay = 4'd3;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              core_rst_n;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    rstgen_top #(
        .DLY_W  (DLY_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_rstgen_top (
        .clk        (clk),
        .por_req    (por_req),
        .bod_det    (bod_det),
        .wdt_expire (wdt_expire),
        .ext_rst_n  (ext_rst_n),
        .supply_ok  (supply_ok),
        .osc_ok     (osc_ok),
        .cfg_delay  (cfg_delay),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .core_rst_n (core_rst_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input logic [4:0] exp, input string req);
        reg_addr = 2'd0;
        #0.1;
        check(reg_rdata == {3'b000, exp}, req, "cause flags", reg_rdata, {3'b000, exp});
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        reg_addr  = 2'd0;
    endtask

    task automatic wdt_pulse();
        @(negedge clk);
        wdt_expire = 1'b1;
        @(posedge clk);
        #1;
        wdt_expire = 1'b0;
    endtask

    // counts edges from the next one (E0 = 1) until core_rst_n is high
    task automatic expect_release(input int exp, input string req);
        int n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!core_rst_n && n < 100);
        check(n == exp, req, "release edge", n, exp);
    endtask

    task automatic t_power_on();
        #1 por_req = 1'b1;
        #0.5;
        check(core_rst_n == 1'b0, "R1", "reset during por", core_rst_n, 0);
        check_flags(5'h01, "R1");
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_req = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R2", "held while supply low", core_rst_n, 0);
    endtask

    task automatic t_first_release();
        @(negedge clk);
        supply_ok = 1'b1;
        osc_ok    = 1'b1;
        expect_release(3 + 2, "R3");
        check_flags(5'h01, "R3");
    endtask

    task automatic t_clear();
        reg_write(2'd0, 8'h00);
        check_flags(5'h01, "R9");
        reg_write(2'd0, 8'h01);
        check_flags(5'h00, "R9");
    endtask

    task automatic t_watchdog();
        wdt_pulse();
        check(core_rst_n == 1'b0, "R4", "wdt asserts reset", core_rst_n, 0);
        check_flags(5'h04, "R4");
        expect_release(3 + 2, "R4");
    endtask

    task automatic t_software();
        reg_write(2'd1, 8'h5A);
        check(core_rst_n == 1'b1, "R7", "wrong key ignored", core_rst_n, 1);
        check_flags(5'h04, "R7");
        reg_write(2'd1, 8'hA5);
        check(core_rst_n == 1'b0, "R7", "key asserts reset", core_rst_n, 0);
        check_flags(5'h14, "R8");
        expect_release(3 + 2, "R7");
    endtask

    task automatic t_pin();
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(core_rst_n == 1'b1, "R5", "pin still in sync chain", core_rst_n, 1);
        @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R5", "pin asserts reset", core_rst_n, 0);
        repeat (6) @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R5", "held while pin low", core_rst_n, 0);
        check_flags(5'h1C, "R8");
        @(negedge clk);
        ext_rst_n = 1'b1;
        expect_release(3 + 4, "R5");
    endtask

    task automatic t_brownout();
        @(negedge clk);
        bod_det = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(core_rst_n == 1'b1, "R6", "bod still in sync chain", core_rst_n, 1);
        @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R6", "bod asserts reset", core_rst_n, 0);
        reg_write(2'd0, 8'h02);
        check_flags(5'h1E, "R9");
        repeat (4) @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R6", "held while bod high", core_rst_n, 0);
        @(negedge clk);
        bod_det = 1'b0;
        expect_release(3 + 4, "R6");
    endtask

    task automatic t_restart();
        cfg_delay = 4'd10;
        wdt_pulse();
        repeat (6) @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R10", "still counting", core_rst_n, 0);
        wdt_pulse();
        expect_release(10 + 2, "R10");
    endtask

    task automatic t_delay_limits();
        reg_write(2'd0, 8'h1F);
        check_flags(5'h00, "R9");
        cfg_delay = 4'd0;
        @(negedge clk);
        supply_ok = 1'b0;
        @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R2", "supply drop resets", core_rst_n, 0);
        check_flags(5'h00, "R2");
        @(negedge clk);
        supply_ok = 1'b1;
        expect_release(0 + 2, "R3");
        cfg_delay = 4'd15;
        @(negedge clk);
        osc_ok = 1'b0;
        @(posedge clk);
        #1;
        check(core_rst_n == 1'b0, "R2", "osc drop resets", core_rst_n, 0);
        @(negedge clk);
        osc_ok = 1'b1;
        expect_release(15 + 2, "R3");
    endtask

    task automatic t_read_map();
        wdt_pulse();
        reg_addr = 2'd2;
        #0.1;
        check(reg_rdata == 8'h00, "R11", "unmapped read", reg_rdata, 8'h00);
        reg_addr = 2'd1;
        #0.1;
        check(reg_rdata == 8'h00, "R11", "key reg read", reg_rdata, 8'h00);
        check_flags(5'h04, "R11");
        expect_release(15 + 2, "R11");
    endtask

    task automatic t_power_again();
        @(negedge clk);
        por_req = 1'b1;
        #0.5;
        check(core_rst_n == 1'b0, "R1", "async por", core_rst_n, 0);
        check_flags(5'h01, "R1");
        @(negedge clk);
        por_req = 1'b0;
        expect_release(15 + 2, "R1");
    endtask

    initial begin
        t_power_on();
        t_first_release();
        t_clear();
        t_watchdog();
        t_software();
        t_pin();
        t_brownout();
        t_restart();
        t_delay_limits();
        t_read_map();
        t_power_again();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule